// File: doc/BRIEF.md
# Bank Window Bus-Master Sequencer

This block lets an expansion card act as bus master on a 65xx-style host that has an 8-bit data bus and a 16-bit address space. The host reaches its banked RAM through an 8 KB window, and the number of the visible bank lives in a register at address 0x0000. The card fills in a request: the bank it wants, a 13-bit starting offset inside the window, a byte count and a direction. The sequencer then waits for a safe moment. That moment is an opcode-fetch cycle, reported by the CPU's sync output, while the host grants the transfer and no interrupt service is active. At that point it halts the CPU and takes the bus.

Once it holds the bus, the sequencer runs a fixed series of cycles:

1. It reads the bank register and keeps the value.
2. It writes the requested bank number to the bank register.
3. It moves the block of bytes through the window, with the address wrapping inside the 8 KB window.
4. It writes the kept value back to the bank register.

It then lets go of the bus, lets the CPU run again and pulses `done`. Bytes going to the host come from a valid/ready input stream. Bytes read from the host leave on a valid/ready output stream.

Top module: `bank_window_dma`

## Requirements
- R1: While reset is active and just after it: `cpu_run`=1, `bus_oe`=0, `bus_ph2`=0, `done`=0, `in_ready`=0, `out_valid`=0.
- R2: After a `start` pulse taken while idle, `cpu_run` falls only on the clock after an edge at which `cpu_sync`=1, `host_go`=1 and `host_isr_busy`=0 were all sampled. Until then the block keeps waiting.
- R3: `bus_oe` rises exactly GRAB_CLKS clocks after `cpu_run` falls. `bus_oe` is 0 whenever `cpu_run` is 1, and it has been 0 for at least one clock before `cpu_run` rises.
- R4: The first bus cycle after the takeover reads address 0x0000, and the value read is kept.
- R5: The second bus cycle writes the requested bank number to address 0x0000.
- R6: Transfer cycle i (i = 0 .. len-1, in ascending order) uses address WIN_BASE + ((offset + i) mod 8192). The default WIN_BASE is 0xA000.
- R7: Each bus cycle takes two clocks. In phase 1 (`bus_ph2`=0) the address is valid and `bus_rw_n`=1. In phase 2 (`bus_ph2`=1) the address stays the same. A write drives `bus_rw_n`=0 and `bus_dout`. A read samples `bus_din` at the edge that ends phase 2.
- R8: With `req_to_host`=1, each transfer byte is taken from the input stream on a clock with `in_valid`=1 and `in_ready`=1, and then written. While `in_valid`=0 no phase 2 takes place.
- R9: With `req_to_host`=0, the bytes read leave on `out_data` in order. `out_valid` and `out_data` hold until `out_ready`=1. No further bus cycle starts while a byte is waiting.
- R10: The last bus cycle writes the kept value back to 0x0000. `done` is a one-clock pulse in the first clock where `cpu_run` is 1 again.
- R11: With len = 0 the block runs only the read, the bank-select write and the restore write.
- R12: A `start` pulse received while a transfer is running has no effect on that transfer's bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two clocks per host bus cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken only when idle |
| req_bank | input | 8 | RAM bank to select for the transfer |
| req_offset | input | 13 | Starting byte offset inside the window |
| req_len | input | 14 | Number of bytes to move |
| req_to_host | input | 1 | 1 = card to host (writes), 0 = host to card (reads) |
| cpu_sync | input | 1 | CPU opcode-fetch indicator |
| host_go | input | 1 | Host permission to transfer |
| host_isr_busy | input | 1 | High while the host services an interrupt |
| cpu_run | output | 1 | Ready line to the CPU; 0 halts it |
| bus_oe | output | 1 | Card drives the address and control lines |
| bus_addr | output | 16 | Bus address |
| bus_dout | output | 8 | Write data |
| bus_din | input | 8 | Read data from the host bus |
| bus_rw_n | output | 1 | 1 = read, 0 = write |
| bus_ph2 | output | 1 | Second phase of a bus cycle is in progress |
| in_valid | input | 1 | Input byte available |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte taken at this edge |
| out_valid | output | 1 | Output byte available |
| out_data | output | 8 | Byte read from the host |
| out_ready | input | 1 | Consumer accepts the output byte |
| done | output | 1 | Transfer finished and bank restored |

## Verification
Most results can be counted from a sampled input:

- `cpu_run` falls one clock after the edge that sees the permit conditions.
- `bus_oe` rises GRAB_CLKS clocks after that.
- Each bus cycle then takes two clocks, stretched only by stream stalls.
- `done` comes one clock after `bus_oe` falls.

The bench samples on falling edges and checks these counts against running observations of the previous sample: it counts the grab clocks and compares the phase-1 address with the phase-2 address. This way, cycles stretched by stalls are checked by order rather than by absolute time. The scoreboard matches every phase-2 cycle against a queue filled from the request, so address and data ordering are checked however long each stall lasts.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_SYNC,
        ST_GRAB,
        ST_READ_BANK,
        ST_WRITE_BANK,
        ST_XFER,
        ST_RESTORE,
        ST_RELEASE
    } bwd_state_e;

    function automatic logic is_bus_state(input bwd_state_e s);
        return (s == ST_READ_BANK) || (s == ST_WRITE_BANK) ||
               (s == ST_XFER)      || (s == ST_RESTORE);
    endfunction

endpackage

// File: rtl/bwd_addr_gen.sv
module bwd_addr_gen
    import bwd_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int WIN_AW   = 13,
    parameter int LEN_W    = 14,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'hA000,
    parameter logic [ADDR_W-1:0] BANK_ADDR = 16'h0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  bwd_state_e         state,
    input  logic               ph2,
    input  logic               to_host,
    input  logic [WIN_AW-1:0]  offset,
    input  logic [LEN_W-1:0]   idx,
    input  logic [DATA_W-1:0]  bank,
    input  logic [DATA_W-1:0]  saved,
    input  logic [DATA_W-1:0]  wdata,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_dout,
    output logic               bus_rw_n
);

    logic [WIN_AW-1:0] win_off;
    logic              wr_cycle;

    // offset wraps inside the window
    assign win_off = offset + idx[WIN_AW-1:0];

    always_comb begin
        bus_addr = BANK_ADDR;
        bus_dout = wdata;
        wr_cycle = 1'b0;
        case (state)
            ST_WRITE_BANK: begin
                bus_dout = bank;
                wr_cycle = 1'b1;
            end
            ST_RESTORE: begin
                bus_dout = saved;
                wr_cycle = 1'b1;
            end
            ST_XFER: begin
                bus_addr = WIN_BASE + ADDR_W'(win_off);
                wr_cycle = to_host;
            end
            default: ;
        endcase
    end

    // R/W goes low only in the second phase of a write
    assign bus_rw_n = !(wr_cycle && ph2);

    a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        ph2 |-> $stable(bus_addr) && $past(bus_rw_n) && !$past(ph2));

    a_r7_ph2_in_bus_state: assert property (@(posedge clk) disable iff (!rst_n)
        ph2 |-> is_bus_state(state));

endmodule

// File: rtl/bwd_seq.sv
module bwd_seq
    import bwd_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int WIN_AW    = 13,
    parameter int LEN_W     = 14,
    parameter int GRAB_CLKS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DATA_W-1:0]  req_bank,
    input  logic [WIN_AW-1:0]  req_offset,
    input  logic [LEN_W-1:0]   req_len,
    input  logic               req_to_host,
    input  logic               cpu_sync,
    input  logic               host_go,
    input  logic               host_isr_busy,
    input  logic [DATA_W-1:0]  bus_din,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               out_ready,
    output bwd_state_e         state,
    output logic               ph2,
    output logic               to_host,
    output logic [WIN_AW-1:0]  offset,
    output logic [LEN_W-1:0]   idx,
    output logic [DATA_W-1:0]  bank,
    output logic [DATA_W-1:0]  saved,
    output logic [DATA_W-1:0]  wdata,
    output logic               in_ready,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data,
    output logic               cpu_run,
    output logic               bus_oe,
    output logic               done
);

    localparam int GRAB_W = (GRAB_CLKS > 1) ? $clog2(GRAB_CLKS) : 1;
    localparam logic [GRAB_W-1:0] GRAB_LAST = GRAB_W'(GRAB_CLKS - 1);

    typedef struct packed {
        bwd_state_e        state;
        logic              ph2;
        logic [GRAB_W-1:0] grab;
        logic [DATA_W-1:0] bank;
        logic [DATA_W-1:0] saved;
        logic [WIN_AW-1:0] off;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  idx;
        logic              dir;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rd;
        logic              out_valid;
        logic              run;
        logic              oe;
        logic              done;
    } seq_t;

    seq_t r_q, r_d;

    logic permit;
    assign permit = cpu_sync && host_go && !host_isr_busy;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (r_q.out_valid && out_ready) begin
            r_d.out_valid = 1'b0;
        end
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.bank  = req_bank;
                    r_d.off   = req_offset;
                    r_d.len   = req_len;
                    r_d.dir   = req_to_host;
                    r_d.state = ST_WAIT_SYNC;
                end
            end
            ST_WAIT_SYNC: begin
                if (permit) begin
                    r_d.run   = 1'b0;
                    r_d.grab  = '0;
                    r_d.state = ST_GRAB;
                end
            end
            ST_GRAB: begin
                if (r_q.grab == GRAB_LAST) begin
                    r_d.oe    = 1'b1;
                    r_d.ph2   = 1'b0;
                    r_d.state = ST_READ_BANK;
                end else begin
                    r_d.grab = r_q.grab + 1'b1;
                end
            end
            ST_READ_BANK: begin
                if (!r_q.ph2) begin
                    r_d.ph2 = 1'b1;
                end else begin
                    r_d.ph2   = 1'b0;
                    r_d.saved = bus_din;
                    r_d.state = ST_WRITE_BANK;
                end
            end
            ST_WRITE_BANK: begin
                if (!r_q.ph2) begin
                    r_d.ph2 = 1'b1;
                end else begin
                    r_d.ph2   = 1'b0;
                    r_d.idx   = '0;
                    r_d.state = (r_q.len == '0) ? ST_RESTORE : ST_XFER;
                end
            end
            ST_XFER: begin
                if (!r_q.ph2) begin
                    if (r_q.dir) begin
                        if (in_valid) begin
                            r_d.wdata = in_data;
                            r_d.ph2   = 1'b1;
                        end
                    end else if (!r_q.out_valid) begin
                        r_d.ph2 = 1'b1;
                    end
                end else begin
                    r_d.ph2 = 1'b0;
                    if (!r_q.dir) begin
                        r_d.rd        = bus_din;
                        r_d.out_valid = 1'b1;
                    end
                    r_d.idx = r_q.idx + 1'b1;
                    if (r_q.idx == r_q.len - LEN_W'(1)) begin
                        r_d.state = ST_RESTORE;
                    end
                end
            end
            ST_RESTORE: begin
                if (!r_q.ph2) begin
                    if (!r_q.out_valid) begin
                        r_d.ph2 = 1'b1;
                    end
                end else begin
                    r_d.ph2   = 1'b0;
                    r_d.oe    = 1'b0;
                    r_d.state = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                r_d.run   = 1'b1;
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.run   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign state     = r_q.state;
    assign ph2       = r_q.ph2;
    assign to_host   = r_q.dir;
    assign offset    = r_q.off;
    assign idx       = r_q.idx;
    assign bank      = r_q.bank;
    assign saved     = r_q.saved;
    assign wdata     = r_q.wdata;
    assign out_valid = r_q.out_valid;
    assign out_data  = r_q.rd;
    assign cpu_run   = r_q.run;
    assign bus_oe    = r_q.oe;
    assign done      = r_q.done;
    assign in_ready  = (r_q.state == ST_XFER) && r_q.dir && !r_q.ph2;

    a_r2_halt_on_permit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_run) |-> $past(cpu_sync && host_go && !host_isr_busy));

    a_r3_no_drive_while_running: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !cpu_run);

    a_r3_release_before_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_run) |-> !bus_oe && $past(!bus_oe));

    a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    a_r10_done_after_restore: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cpu_run && !bus_oe && $past(state == ST_RELEASE));

    a_r1_ph2_needs_bus: assert property (@(posedge clk) disable iff (!rst_n)
        ph2 |-> bus_oe);

endmodule

// File: rtl/bank_window_dma.sv
module bank_window_dma
    import bwd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int WIN_AW    = 13,
    parameter int LEN_W     = 14,
    parameter int GRAB_CLKS = 2,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'hA000,
    parameter logic [ADDR_W-1:0] BANK_ADDR = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] req_bank,
    input  logic [WIN_AW-1:0] req_offset,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_to_host,
    input  logic              cpu_sync,
    input  logic              host_go,
    input  logic              host_isr_busy,
    output logic              cpu_run,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din,
    output logic              bus_rw_n,
    output logic              bus_ph2,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    output logic              done
);

    bwd_state_e        st;
    logic              ph2;
    logic              to_host;
    logic [WIN_AW-1:0] offset;
    logic [LEN_W-1:0]  idx;
    logic [DATA_W-1:0] bank;
    logic [DATA_W-1:0] saved;
    logic [DATA_W-1:0] wdata;

    bwd_seq #(
        .DATA_W(DATA_W), .WIN_AW(WIN_AW), .LEN_W(LEN_W), .GRAB_CLKS(GRAB_CLKS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_bank(req_bank), .req_offset(req_offset), .req_len(req_len),
        .req_to_host(req_to_host), .cpu_sync(cpu_sync), .host_go(host_go),
        .host_isr_busy(host_isr_busy), .bus_din(bus_din),
        .in_valid(in_valid), .in_data(in_data), .out_ready(out_ready),
        .state(st), .ph2(ph2), .to_host(to_host), .offset(offset), .idx(idx),
        .bank(bank), .saved(saved), .wdata(wdata), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .cpu_run(cpu_run),
        .bus_oe(bus_oe), .done(done)
    );

    bwd_addr_gen #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_AW(WIN_AW), .LEN_W(LEN_W),
        .WIN_BASE(WIN_BASE), .BANK_ADDR(BANK_ADDR)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .state(st), .ph2(ph2), .to_host(to_host),
        .offset(offset), .idx(idx), .bank(bank), .saved(saved), .wdata(wdata),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_rw_n(bus_rw_n)
    );

    assign bus_ph2 = ph2;

endmodule

// File: tb/bank_window_dma_bench.sv
module bank_window_dma_bench;

    localparam int GRAB = 2;
    localparam logic [15:0] WBASE = 16'hA000;

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0;
    logic [7:0]  req_bank = 0;
    logic [12:0] req_offset = 0;
    logic [13:0] req_len = 0;
    logic req_to_host = 0;
    logic cpu_sync = 1, host_go = 1, host_isr_busy = 0;
    logic cpu_run, bus_oe, bus_rw_n, bus_ph2, in_ready, out_valid, done;
    logic [15:0] bus_addr;
    logic [7:0]  bus_dout, bus_din, out_data, in_data;
    logic in_valid, out_ready;

    always #10 clk = ~clk;

    bank_window_dma #(.GRAB_CLKS(GRAB)) u_bank_window_dma (
        .clk(clk), .rst_n(rst_n), .start(start), .req_bank(req_bank),
        .req_offset(req_offset), .req_len(req_len), .req_to_host(req_to_host),
        .cpu_sync(cpu_sync), .host_go(host_go), .host_isr_busy(host_isr_busy),
        .cpu_run(cpu_run), .bus_oe(bus_oe), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_din(bus_din), .bus_rw_n(bus_rw_n),
        .bus_ph2(bus_ph2), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .done(done)
    );

    int n_checks = 0, n_fail = 0;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // host model: bank register plus a computed window content
    logic [7:0] host_bank = 8'h00;
    function automatic logic [7:0] host_pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction
    assign bus_din = (bus_addr == 16'h0000) ? host_bank : host_pat(bus_addr);

    // input stream feeder
    logic [7:0] feed_seed = 0;
    int  feed_idx = 0;
    int  gap = 0;
    logic feed_en = 1, feed_gap = 0;
    function automatic logic [7:0] in_pat(input int i);
        return 8'(i * 37) + feed_seed;
    endfunction
    assign in_valid = feed_en && (gap == 0);
    assign in_data  = in_pat(feed_idx);

    always begin
        @(negedge clk);
        if (in_valid && in_ready) begin
            @(posedge clk); #1;
            feed_idx++;
            if (feed_gap && (feed_idx % 4 == 2)) gap = 2;
        end else if (gap > 0) begin
            @(posedge clk); #1;
            gap--;
        end
    end

    // output stream consumer
    logic out_hold = 0, out_throttle = 0;
    int tcnt = 0;
    always begin
        @(posedge clk); #1;
        tcnt++;
    end
    assign out_ready = !out_hold && (!out_throttle || (tcnt % 3 != 0));

    // scoreboard
    typedef struct {
        logic        rwn;
        logic [15:0] addr;
        logic [7:0]  data;
        string       tag;
    } item_t;
    item_t exp_q[$];
    logic [7:0] out_q[$];

    task automatic push(input logic rwn, input logic [15:0] a, input logic [7:0] d, input string tag);
        item_t it;
        it.rwn = rwn; it.addr = a; it.data = d; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic plan(input logic [7:0] bank, input logic [12:0] off, input int len, input logic dir);
        push(1'b1, 16'h0000, host_bank, "R4 save read");
        push(1'b0, 16'h0000, bank, "R5 bank select");
        for (int i = 0; i < len; i++) begin
            logic [15:0] a;
            a = WBASE + 16'(13'(off + 13'(i)));
            if (dir) push(1'b0, a, in_pat(i), "R8 R6 window write");
            else begin
                push(1'b1, a, host_pat(a), "R6 window read");
                out_q.push_back(host_pat(a));
            end
        end
        push(1'b0, 16'h0000, host_bank, "R10 restore");
    endtask

    int ph2_cnt = 0;
    logic prev_ph2 = 0, prev_rwn = 1, prev_oe = 0, prev_run = 1;
    logic [15:0] prev_addr = 0;
    int grab_n = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!cpu_run && prev_run) grab_n = 0;
            if (!cpu_run && !bus_oe) grab_n++;
            if (bus_oe && !prev_oe) check(grab_n == GRAB, "R3 grab delay", grab_n, GRAB);
            if (cpu_run && !prev_run) check(!bus_oe && !prev_oe, "R3 release order", bus_oe, 0);
            if (done) check(cpu_run && !bus_oe && !prev_run, "R10 done timing", cpu_run, 1);
            if (bus_ph2) begin
                ph2_cnt++;
                check(!prev_ph2 && prev_rwn && prev_addr == bus_addr, "R7 phase order", prev_addr, bus_addr);
                if (exp_q.size() == 0) begin
                    check(0, "R6 unexpected bus cycle", bus_addr, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(bus_rw_n == it.rwn && bus_addr == it.addr, it.tag, {bus_rw_n, bus_addr}, {it.rwn, it.addr});
                    if (!it.rwn) check(bus_dout == it.data, it.tag, bus_dout, it.data);
                end
                if (!bus_rw_n && bus_addr == 16'h0000) host_bank = bus_dout;
            end
            if (out_valid && out_ready) begin
                if (out_q.size() == 0) check(0, "R9 unexpected byte", out_data, 0);
                else begin
                    logic [7:0] e;
                    e = out_q.pop_front();
                    check(out_data == e, "R9 stream order", out_data, e);
                end
            end
        end
        prev_ph2 = bus_ph2; prev_rwn = bus_rw_n; prev_addr = bus_addr;
        prev_oe = bus_oe; prev_run = cpu_run;
    end

    task automatic kick(input logic [7:0] bank, input logic [12:0] off, input int len, input logic dir);
        @(posedge clk); #1;
        feed_idx = 0;
        req_bank = bank; req_offset = off; req_len = 14'(len); req_to_host = dir;
        start = 1;
        @(posedge clk); #1;
        start = 0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic finish_run(input logic [7:0] orig, input string tag);
        wait_done();
        check(host_bank == orig, "R10 bank restored", host_bank, orig);
        check(exp_q.size() == 0, {tag, " all cycles seen"}, exp_q.size(), 0);
        check(out_q.size() == 0, {tag, " all bytes out"}, out_q.size(), 0);
    endtask

    logic finished = 0;

    initial begin
        repeat (3) @(negedge clk);
        check(cpu_run && !bus_oe && !bus_ph2 && !done && !in_ready && !out_valid,
              "R1 reset state", {cpu_run, bus_oe, bus_ph2, done}, 4'b1000);
        @(posedge clk); #1; rst_n = 1;
        @(negedge clk);
        check(cpu_run && !bus_oe && !out_valid, "R1 after reset", {cpu_run, bus_oe}, 2'b10);

        // gating of the takeover, then a read transfer
        host_bank = 8'h11;
        cpu_sync = 0; host_go = 1; host_isr_busy = 0;
        plan(8'h05, 13'd16, 6, 1'b0);
        kick(8'h05, 13'd16, 6, 1'b0);
        repeat (8) @(negedge clk);
        check(cpu_run && !bus_oe, "R2 no sync", cpu_run, 1);
        @(posedge clk); #1; cpu_sync = 1; host_isr_busy = 1;
        repeat (8) @(negedge clk);
        check(cpu_run && !bus_oe, "R2 isr busy", cpu_run, 1);
        @(posedge clk); #1; host_isr_busy = 0; host_go = 0;
        repeat (8) @(negedge clk);
        check(cpu_run && !bus_oe, "R2 no go-ahead", cpu_run, 1);
        @(posedge clk); #1; host_go = 1;
        @(negedge clk);
        check(cpu_run, "R2 not before edge", cpu_run, 1);
        @(negedge clk);
        check(!cpu_run, "R2 halt after permit", cpu_run, 0);
        finish_run(8'h11, "R6 read");

        // write transfer with input gaps, and a start pulse while busy
        host_bank = 8'h07; feed_seed = 8'h21; feed_gap = 1;
        plan(8'h22, 13'd100, 10, 1'b1);
        kick(8'h22, 13'd100, 10, 1'b1);
        repeat (12) @(negedge clk);
        @(posedge clk); #1;
        req_bank = 8'h99; req_offset = 13'd3; req_len = 14'd1; req_to_host = 0; start = 1;
        @(posedge clk); #1; start = 0;
        finish_run(8'h07, "R12 R8 write");
        feed_gap = 0;
        repeat (10) @(negedge clk);
        check(cpu_run && exp_q.size() == 0, "R12 ignored start", exp_q.size(), 0);

        // read across the window end with throttled consumer
        host_bank = 8'h3C; out_throttle = 1;
        plan(8'h40, 13'd8190, 5, 1'b0);
        kick(8'h40, 13'd8190, 5, 1'b0);
        finish_run(8'h3C, "R6 wrap");
        out_throttle = 0;

        // zero length
        host_bank = 8'h08;
        plan(8'h77, 13'd0, 0, 1'b0);
        kick(8'h77, 13'd0, 0, 1'b0);
        finish_run(8'h08, "R11 zero length");

        // write stall: input stream empty
        begin
            int base;
            host_bank = 8'h01; feed_seed = 8'h80; feed_en = 0;
            base = ph2_cnt;
            plan(8'h02, 13'd500, 3, 1'b1);
            kick(8'h02, 13'd500, 3, 1'b1);
            repeat (40) @(negedge clk);
            check(ph2_cnt - base == 2, "R8 stall without input", ph2_cnt - base, 2);
            @(posedge clk); #1; feed_en = 1;
            finish_run(8'h01, "R8 stall");
        end

        // read stall: consumer not ready
        begin
            int base;
            host_bank = 8'h55; out_hold = 1;
            base = ph2_cnt;
            plan(8'h66, 13'd7000, 3, 1'b0);
            kick(8'h66, 13'd7000, 3, 1'b0);
            repeat (40) @(negedge clk);
            check(ph2_cnt - base == 3, "R9 stall on pending byte", ph2_cnt - base, 3);
            check(out_valid, "R9 byte held", out_valid, 1);
            @(posedge clk); #1; out_hold = 0;
            finish_run(8'h55, "R9 stall");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule